// File: doc/BRIEF.md
# Threshold and Orientation Interrupt Generator

This block watches a stream of signed three-axis acceleration samples and decides, one sample period at a time, whether to raise an interrupt. Each axis is compared against a programmable threshold in both directions, which gives six event flags: high and low for X, Y and Z. A two-bit combination mode turns those flags into a single condition. The condition is either the OR of the enabled flags, the AND of the enabled flags, a one-period pulse when the orientation moves into a known zone, or a level that stays high while the orientation remains in a known zone.

The condition can be required to persist over a run of consecutive samples before the interrupt fires. The result appears on a source word and on an interrupt pin. The host reads the source word by pulsing a read strobe, which clears the pending interrupt. When latching is enabled, a fired interrupt freezes the source word until that read.

Control is centred on a three-state machine in `motint_irq_fsm`:

- **IRQ_IDLE**: no interrupt is pending. A sample that hits moves it to IRQ_ACTIVE, or to IRQ_LATCHED when latching is on.
- **IRQ_ACTIVE**: the interrupt is showing for the current sample period. A sample that hits keeps it in IRQ_ACTIVE, or sends it to IRQ_LATCHED when latching is on. A sample that misses returns it to IRQ_IDLE. A read with no sample in the same cycle also returns it to IRQ_IDLE.
- **IRQ_LATCHED**: the interrupt and the flags are frozen while samples go on arriving. A read returns it to IRQ_IDLE. If a sample arrives in the same cycle as the read and that sample hits, it re-enters IRQ_ACTIVE or IRQ_LATCHED instead.

Top module: `motion_irq_gen`

## Requirements
- R1: With T = `thresh` << (SAMPLE_W-1-THR_W), which is `thresh`·256 by default, an axis flags high when its signed value is greater than T and low when it is less than -T. The source word carries the flags as bits [5:0] = {ZH, ZL, YH, YL, XH, XL}. Bit 6 is interrupt-active, and `irq` always equals bit 6.
- R2: With `mode` = 00, a sample hits when any flag whose bit in `evt_en` (same bit order as the flags) is set is true.
- R3: With `mode` = 10, a sample hits only when every enabled flag is true. With `evt_en` = 0, a sample never hits.
- R4: With `mode` = 11, a sample hits while the orientation is known, meaning exactly one considered axis is beyond ±T.
- R5: With `mode` = 01, a sample hits only when the known-zone condition (after the duration filter) is true now and was false on the previous sample. This gives a one-period pulse. Moving from one known zone straight to another gives no pulse.
- R6: With `use_4d` = 1 in modes 01 and 11, Z is left out of the known-zone test and ZH/ZL are reported as 0.
- R7: The combined condition must hold on `dur` earlier consecutive samples before a hit is produced, so the interrupt asserts on the (dur+1)-th consecutive sample. A sample on which the condition is false restarts the count. With `dur` = 0, the interrupt asserts on the first sample.
- R8: Outputs change only at an edge with `sample_valid` or `src_rd` high. `irq` can rise only at an edge with `sample_valid`.
- R9: A `src_rd` pulse with no sample in the same cycle clears `irq` and bit 6 at that edge. When the source word is not latched, the flags are left unchanged by the read.
- R10: With `latch_en` = 1, a hit holds `irq` and freezes the flags across later samples until a read. The first sample after the read refreshes them.
- R11: After reset, `src_word` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_valid | input | 1 | A new X/Y/Z sample is present this cycle |
| x_in | input | SAMPLE_W | Signed X sample |
| y_in | input | SAMPLE_W | Signed Y sample |
| z_in | input | SAMPLE_W | Signed Z sample |
| evt_en | input | 6 | Event enables {ZH,ZL,YH,YL,XH,XL} |
| thresh | input | THR_W | Threshold, scaled to the top of the sample range |
| dur | input | DUR_W | Required count of earlier consecutive qualifying samples |
| latch_en | input | 1 | Hold the source word until read |
| mode | input | 2 | 00 OR, 01 movement, 10 AND, 11 position |
| use_4d | input | 1 | Leave Z out of orientation modes |
| src_rd | input | 1 | Read strobe for the source word |
| src_word | output | 7 | {active, ZH, ZL, YH, YL, XH, XL} |
| irq | output | 1 | Interrupt output |

## Verification
The assertions assume that `sample_valid` and `src_rd` are single-cycle pulses. They also assume that `latch_en` changes only while no sample arrives and is followed by a read before the next sample. Otherwise an unlatched active interrupt could be seen as latched. The stimulus keeps within this by never raising the strobes together and by issuing a read after every change of configuration, before any further samples. The random samples are drawn to sit on both sides of ±T and at exactly ±T, and the orientation modes favour one-axis-dominant vectors so that known zones are entered and left often.

// File: rtl/motint_pkg.sv
package motint_pkg;

    typedef enum logic [1:0] {
        CMB_OR   = 2'b00,
        CMB_MOVE = 2'b01,
        CMB_AND  = 2'b10,
        CMB_POS  = 2'b11
    } cmb_mode_e;

    typedef enum logic [1:0] {
        IRQ_IDLE    = 2'b00,
        IRQ_ACTIVE  = 2'b01,
        IRQ_LATCHED = 2'b10
    } irq_state_e;

    localparam int AXES   = 3;
    localparam int FLAG_W = 2 * AXES;

endpackage

// File: rtl/motint_axis_cmp.sv
module motint_axis_cmp #(
    parameter int SAMPLE_W = 16,
    parameter int THR_W    = 7
) (
    input  logic signed [SAMPLE_W-1:0] val,
    input  logic        [THR_W-1:0]    thr,
    output logic                       over_hi,
    output logic                       under_lo
);
    localparam int SHIFT = SAMPLE_W - 1 - THR_W;
    localparam int EXT_W = SAMPLE_W + 1;

    logic signed [EXT_W-1:0] val_x;
    logic signed [EXT_W-1:0] lim_p;
    logic signed [EXT_W-1:0] lim_n;

    always_comb begin
        val_x    = {val[SAMPLE_W-1], val};
        lim_p    = $signed(EXT_W'(thr) << SHIFT);
        lim_n    = -lim_p;
        over_hi  = (val_x > lim_p);
        under_lo = (val_x < lim_n);
    end

endmodule

// File: rtl/motint_combine.sv
module motint_combine
    import motint_pkg::*;
(
    input  logic [AXES-1:0]   hi,
    input  logic [AXES-1:0]   lo,
    input  logic [FLAG_W-1:0] evt_en,
    input  logic [1:0]        mode,
    input  logic              use_4d,
    output logic              cond,
    output logic              move,
    output logic [FLAG_W-1:0] rep_flags
);
    cmb_mode_e         cmb;
    logic [FLAG_W-1:0] raw;
    logic [AXES-1:0]   exceed;
    logic              known;
    logic              orient;

    always_comb begin
        for (int a = 0; a < AXES; a++) begin
            raw[2*a+1] = hi[a];
            raw[2*a]   = lo[a];
        end
        exceed = hi | lo;
        cmb    = cmb_mode_e'(mode);
        orient = (cmb == CMB_MOVE) || (cmb == CMB_POS);
        if (use_4d)
            known = exceed[1] ^ exceed[0];
        else
            known = ($countones(exceed) == 1);

        unique case (cmb)
            CMB_OR:   cond = |(raw & evt_en);
            CMB_AND:  cond = (evt_en != '0) && ((raw & evt_en) == evt_en);
            CMB_MOVE: cond = known;
            CMB_POS:  cond = known;
            default:  cond = 1'b0;
        endcase

        move      = (cmb == CMB_MOVE);
        rep_flags = raw;
        if (orient && use_4d)
            rep_flags[FLAG_W-1 -: 2] = 2'b00;
    end

endmodule

// File: rtl/motint_irq_fsm.sv
module motint_irq_fsm
    import motint_pkg::*;
#(
    parameter int DUR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp,
    input  logic              cond,
    input  logic              move,
    input  logic              latch_en,
    input  logic              rd,
    input  logic [DUR_W-1:0]  dur,
    input  logic [FLAG_W-1:0] new_flags,
    output logic [FLAG_W:0]   src_word,
    output logic              irq
);
    localparam logic [DUR_W-1:0] CNT_MAX = '1;

    irq_state_e        state_q, state_n;
    logic [DUR_W-1:0]  cnt_q, cnt_n;
    logic              prevq_q;
    logic [FLAG_W-1:0] flags_q;
    logic              qual;
    logic              hit;
    logic              flags_we;
    irq_state_e        hit_dest;

    always_comb begin
        qual     = cond && (cnt_q >= dur);
        hit      = move ? (qual && !prevq_q) : qual;
        hit_dest = latch_en ? IRQ_LATCHED : IRQ_ACTIVE;
        if (!cond)
            cnt_n = '0;
        else if (cnt_q != CNT_MAX)
            cnt_n = cnt_q + 1'b1;
        else
            cnt_n = cnt_q;

        state_n = state_q;
        unique case (state_q)
            IRQ_IDLE: begin
                if (smp && hit)
                    state_n = hit_dest;
            end
            IRQ_ACTIVE: begin
                if (smp)
                    state_n = hit ? hit_dest : IRQ_IDLE;
                else if (rd)
                    state_n = IRQ_IDLE;
            end
            IRQ_LATCHED: begin
                if (rd)
                    state_n = (smp && hit) ? hit_dest : IRQ_IDLE;
            end
            default: state_n = IRQ_IDLE;
        endcase

        flags_we = smp && ((state_q != IRQ_LATCHED) || rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
            cnt_q   <= '0;
            prevq_q <= 1'b0;
            flags_q <= '0;
        end else begin
            state_q <= state_n;
            if (smp) begin
                cnt_q   <= cnt_n;
                prevq_q <= qual;
            end
            if (flags_we)
                flags_q <= new_flags;
        end
    end

    always_comb begin
        irq      = (state_q != IRQ_IDLE);
        src_word = {irq, flags_q};
    end

endmodule

// File: rtl/motion_irq_gen.sv
module motion_irq_gen
    import motint_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int THR_W    = 7,
    parameter int DUR_W    = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sample_valid,
    input  logic signed [SAMPLE_W-1:0] x_in,
    input  logic signed [SAMPLE_W-1:0] y_in,
    input  logic signed [SAMPLE_W-1:0] z_in,
    input  logic [FLAG_W-1:0]          evt_en,
    input  logic [THR_W-1:0]           thresh,
    input  logic [DUR_W-1:0]           dur,
    input  logic                       latch_en,
    input  logic [1:0]                 mode,
    input  logic                       use_4d,
    input  logic                       src_rd,
    output logic [FLAG_W:0]            src_word,
    output logic                       irq
);
    logic signed [SAMPLE_W-1:0] axis_v [AXES];
    logic [AXES-1:0]            hi;
    logic [AXES-1:0]            lo;
    logic                       cond;
    logic                       move;
    logic [FLAG_W-1:0]          rep_flags;

    always_comb begin
        axis_v[0] = x_in;
        axis_v[1] = y_in;
        axis_v[2] = z_in;
    end

    for (genvar g = 0; g < AXES; g++) begin : g_axis
        motint_axis_cmp #(
            .SAMPLE_W (SAMPLE_W),
            .THR_W    (THR_W)
        ) u_cmp (
            .val      (axis_v[g]),
            .thr      (thresh),
            .over_hi  (hi[g]),
            .under_lo (lo[g])
        );
    end

    motint_combine u_combine (
        .hi        (hi),
        .lo        (lo),
        .evt_en    (evt_en),
        .mode      (mode),
        .use_4d    (use_4d),
        .cond      (cond),
        .move      (move),
        .rep_flags (rep_flags)
    );

    motint_irq_fsm #(
        .DUR_W (DUR_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp       (sample_valid),
        .cond      (cond),
        .move      (move),
        .latch_en  (latch_en),
        .rd        (src_rd),
        .dur       (dur),
        .new_flags (rep_flags),
        .src_word  (src_word),
        .irq       (irq)
    );

endmodule

// File: rtl/motion_irq_gen_chk.sv
module motion_irq_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sample_valid,
    input logic       src_rd,
    input logic       latch_en,
    input logic [6:0] src_word,
    input logic       irq
);
    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (src_rd && !sample_valid) |=> (!irq && !src_word[6]));

    assert_rise_needs_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> !$rose(irq));

    assert_quiet_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_valid && !src_rd) |=> ($stable(src_word) && $stable(irq)));

    assert_latched_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && irq && !src_rd) |=> (irq && $stable(src_word)));

    assert_hilo_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !((src_word[5] && src_word[4]) || (src_word[3] && src_word[2]) ||
          (src_word[1] && src_word[0])));

    assert_pin_matches_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq == src_word[6]);

endmodule

bind motion_irq_gen motion_irq_gen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .src_rd       (src_rd),
    .latch_en     (latch_en),
    .src_word     (src_word),
    .irq          (irq)
);

// File: tb/motion_irq_gen_tb_top.sv
module motion_irq_gen_tb_top;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               sample_valid = 1'b0;
    logic signed [15:0] x_in = '0;
    logic signed [15:0] y_in = '0;
    logic signed [15:0] z_in = '0;
    logic [5:0]         evt_en = '0;
    logic [6:0]         thresh = '0;
    logic [6:0]         dur = '0;
    logic               latch_en = 1'b0;
    logic [1:0]         mode = 2'b00;
    logic               use_4d = 1'b0;
    logic               src_rd = 1'b0;
    logic [6:0]         src_word;
    logic               irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int   m_cnt = 0;
    bit   m_prevq = 0;
    bit   m_ia = 0;
    bit   m_held = 0;
    logic [5:0] m_flags = '0;

    always #5 clk = ~clk;

    motion_irq_gen dut_i (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .x_in(x_in), .y_in(y_in), .z_in(z_in), .evt_en(evt_en),
        .thresh(thresh), .dur(dur), .latch_en(latch_en), .mode(mode),
        .use_4d(use_4d), .src_rd(src_rd), .src_word(src_word), .irq(irq)
    );

    function automatic int lim();
        return int'(thresh) * 256;
    endfunction

    function automatic logic [5:0] raw_flags(int x, int y, int z);
        int t = lim();
        return {z > t, z < -t, y > t, y < -t, x > t, x < -t};
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_out(string req);
        chk(req, {irq, src_word}, {m_ia, m_ia, m_flags});
    endtask

    task automatic model_sample(int x, int y, int z);
        logic [5:0] f;
        logic [2:0] ex;
        bit known, cond, q, hit;
        f  = raw_flags(x, y, z);
        ex = {f[5] | f[4], f[3] | f[2], f[1] | f[0]};
        known = use_4d ? (ex[1] ^ ex[0]) : ($countones(ex) == 1);
        case (mode)
            2'b00: cond = |(f & evt_en);
            2'b10: cond = (evt_en != 0) && ((f & evt_en) == evt_en);
            default: cond = known;
        endcase
        if (mode[0] && use_4d) f[5:4] = 2'b00;
        q = cond && (m_cnt >= int'(dur));
        m_cnt = cond ? ((m_cnt < 127) ? m_cnt + 1 : m_cnt) : 0;
        hit = (mode == 2'b01) ? (q && !m_prevq) : q;
        m_prevq = q;
        if (!m_held) begin
            m_flags = f;
            m_ia = hit;
            m_held = hit && latch_en;
        end
    endtask

    task automatic do_sample(string req, int x, int y, int z);
        @(negedge clk);
        x_in = 16'(x); y_in = 16'(y); z_in = 16'(z);
        sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
        model_sample(x, y, z);
        check_out(req);
    endtask

    task automatic do_read(string req);
        @(negedge clk);
        src_rd = 1'b1;
        @(negedge clk);
        src_rd = 1'b0;
        m_ia = 0;
        m_held = 0;
        check_out(req);
    endtask

    task automatic set_cfg(logic [1:0] md, logic [5:0] en, logic [6:0] th,
                           logic [6:0] du, logic la, logic d4);
        @(negedge clk);
        mode = md; evt_en = en; thresh = th; dur = du; latch_en = la; use_4d = d4;
        do_read("R9");
    endtask

    function automatic int rnd_axis(bit big);
        int t = lim();
        int span = 32767 - t;
        if (big) begin
            int m = t + 1 + int'($urandom % 32'(span));
            return ($urandom % 2) ? m : -m;
        end
        case ($urandom % 3)
            0: return ($urandom % 2) ? t : -t;
            default: return int'($urandom % 32'(2 * t + 1)) - t;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        chk("R11", {irq, src_word}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", {irq, src_word}, 8'h00);

        // R1: threshold boundary, T = 5*256 = 1280
        set_cfg(2'b00, 6'h3F, 7'd5, 7'd0, 1'b0, 1'b0);
        do_sample("R1", 1280, 0, 0);
        chk("R1", {irq, src_word}, 8'h00);
        do_sample("R1", 1281, 0, 0);
        chk("R1", {irq, src_word}, 8'hC2);
        do_sample("R1", -1280, 0, 0);
        do_sample("R1", -1281, 0, 0);
        chk("R1", {irq, src_word}, 8'hC1);
        do_sample("R1", 0, 0, -32768);
        chk("R1", {irq, src_word}, 8'hD0);
        set_cfg(2'b00, 6'h3F, 7'd0, 7'd0, 1'b0, 1'b0);
        do_sample("R1", 0, 0, 0);
        chk("R1", {irq, src_word}, 8'h00);
        do_sample("R1", 0, 1, 0);
        chk("R1", {irq, src_word}, 8'hC8);

        // R8: quiet cycles keep outputs
        repeat (5) @(negedge clk);
        chk("R8", {irq, src_word}, 8'hC8);
        // R9: read clears active but keeps flags
        do_read("R9");
        chk("R9", {irq, src_word}, 8'h08);

        // R2: OR with only XH enabled ignores others
        set_cfg(2'b00, 6'h02, 7'd10, 7'd0, 1'b0, 1'b0);
        do_sample("R2", 0, 9000, -9000);
        chk("R2", {irq, src_word}, 8'h18);

        // R7: duration of 2
        set_cfg(2'b00, 6'h02, 7'd10, 7'd2, 1'b0, 1'b0);
        do_sample("R7", 3000, 0, 0);
        chk("R7", irq, 1'b0);
        do_sample("R7", 3000, 0, 0);
        chk("R7", irq, 1'b0);
        do_sample("R7", 3000, 0, 0);
        chk("R7", irq, 1'b1);
        do_sample("R7", 0, 0, 0);
        do_sample("R7", 3000, 0, 0);
        chk("R7", irq, 1'b0);

        // R3: AND with nothing enabled never fires
        set_cfg(2'b10, 6'h00, 7'd1, 7'd0, 1'b0, 1'b0);
        do_sample("R3", 5000, 5000, 5000);
        chk("R3", irq, 1'b0);
        set_cfg(2'b10, 6'h0A, 7'd1, 7'd0, 1'b0, 1'b0);
        do_sample("R3", 5000, 5000, 0);
        chk("R3", irq, 1'b1);
        do_sample("R3", 5000, 0, 0);
        chk("R3", irq, 1'b0);

        // R5: movement pulse
        set_cfg(2'b01, 6'h00, 7'd10, 7'd0, 1'b0, 1'b0);
        do_sample("R5", 0, 0, 0);
        do_sample("R5", 4000, 0, 0);
        chk("R5", irq, 1'b1);
        do_sample("R5", 4000, 0, 0);
        chk("R5", irq, 1'b0);
        do_sample("R5", 0, -4000, 0);
        chk("R5", irq, 1'b0);
        do_sample("R5", 0, 0, 0);
        do_sample("R5", 0, 0, 4000);
        chk("R5", irq, 1'b1);

        // R4 and R6: position, 6D versus 4D
        set_cfg(2'b11, 6'h00, 7'd10, 7'd0, 1'b0, 1'b0);
        do_sample("R4", 4000, 0, 4000);
        chk("R4", irq, 1'b0);
        do_sample("R4", 0, 0, -4000);
        chk("R4", {irq, src_word}, 8'hD0);
        do_sample("R4", 0, 0, -4000);
        chk("R4", irq, 1'b1);
        set_cfg(2'b11, 6'h00, 7'd10, 7'd0, 1'b0, 1'b1);
        do_sample("R6", 0, 0, -4000);
        chk("R6", {irq, src_word}, 8'h00);
        do_sample("R6", 4000, 0, 4000);
        chk("R6", {irq, src_word}, 8'hC2);

        // R10: latched hold and refresh
        set_cfg(2'b00, 6'h02, 7'd10, 7'd0, 1'b1, 1'b0);
        do_sample("R10", 4000, 0, 0);
        do_sample("R10", 0, 4000, 0);
        chk("R10", {irq, src_word}, 8'hC2);
        do_read("R10");
        chk("R10", {irq, src_word}, 8'h02);
        do_sample("R10", 0, 4000, 0);
        chk("R10", {irq, src_word}, 8'h08);

        // Random blocks across modes and latching
        for (int blk = 0; blk < 48; blk++) begin
            logic [1:0] md = 2'(blk % 4);
            string tag;
            case (md)
                2'b00: tag = "R2";
                2'b01: tag = "R5";
                2'b10: tag = "R3";
                default: tag = "R4";
            endcase
            if ((blk / 4) % 2 == 1) tag = "R10";
            set_cfg(md, 6'($urandom), 7'($urandom % 128), 7'($urandom % 3),
                    1'((blk / 4) % 2), 1'($urandom % 2));
            for (int op = 0; op < 60; op++) begin
                int sel = int'($urandom % 10);
                if (sel < 7) begin
                    bit one = ($urandom % 2) == 1;
                    int ax = int'($urandom % 3);
                    int vx, vy, vz;
                    vx = rnd_axis(one ? (ax == 0) : (($urandom % 2) == 1));
                    vy = rnd_axis(one ? (ax == 1) : (($urandom % 2) == 1));
                    vz = rnd_axis(one ? (ax == 2) : (($urandom % 2) == 1));
                    do_sample(tag, vx, vy, vz);
                end else if (sel < 9) begin
                    do_read("R9");
                end else begin
                    repeat (2) @(negedge clk);
                    check_out("R8");
                end
            end
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule